// File: doc/BRIEF.md
# ECC Error Capture and Lock

This block sits beside a memory controller and keeps a record of ECC error events for software. Each requesting master has its own error strobe. The strobe comes with the access address, a read/write flag, an error class (correctable or uncorrectable), the memory bank that was hit and a lock request. The block keeps one shared error address register, one syndrome field per master and a set of per-bank error flags.

The address register can be frozen. When the master that wins capture asked for locking and no lock is held yet, its lock flag is set and later errors leave the address alone. The freeze ends when software clears that lock flag in either of the two syndrome registers. Software reaches every register through an indirect pair. A write to the index side selects a register. A read or write on the data side then reads it or clears it. Clearing is write-one-to-clear.

Top module: `ecc_err_capture`

## Requirements
- R1: After reset, all four indexed registers read zero, the index register reads zero and `lock_held` is 0.
- R2: While unlocked, any error strobe (correctable or uncorrectable) loads the address register at the next clock edge. The address comes from the lowest-numbered master strobing in that cycle. Index 0 reads this register.
- R3: A lock is taken only when the capture winner has its lock request high and no lock is already held. It sets that master's lock flag, which is LSB-0 bit 15-j of its syndrome register for slot j = m mod 4. `lock_held` goes to 1. Only one lock flag is ever set.
- R4: While `lock_held` is 1, no error changes the address register.
- R5: Writing 1 to the set lock flag releases the lock at the next edge, and the next error is captured again. Writing 1 to lock positions that are clear does not release the lock.
- R6: An uncorrectable error of master m records type 010 in MSB-0 bits 4j..4j+2 and its direction in MSB-0 bit 4j+3 (1 = read, 0 = write). Here j = m mod 4, and the register is index 1 for masters 0-3 and index 2 for masters 4-7. A correctable error leaves the field unchanged.
- R7: A field already holding a nonzero type keeps its type and direction bit when further errors arrive.
- R8: A data write to index 1, 2 or 3 clears each bit written as 1 and leaves each bit written as 0 unchanged. If the same cycle brings an error into a field that read 000 before the edge, the new record wins.
- R9: Any error of either class in bank b sets MSB-0 bit 16+b (LSB-0 bit 15-b) of the index 3 register.
- R10: Reserved bits read zero and ignore writes. Data writes to index 0 have no effect. Indices above 3 read zero.
- R11: A write with `cfg_sel`=0 loads the low 12 bits of `cfg_wdata` into the index register. A read with `cfg_sel`=0 returns the index. With `cfg_sel`=1, `cfg_rdata` shows the selected register.
- R12: When several masters strobe in the same cycle, each one's own syndrome field and bank flag are updated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| err_valid | input | N_MASTERS | Per-master error strobe |
| err_uncorr | input | N_MASTERS | 1 = uncorrectable, 0 = correctable |
| err_is_read | input | N_MASTERS | 1 = failing access was a read |
| err_lock_req | input | N_MASTERS | Master asks for the address to be locked |
| err_addr | input | N_MASTERS*ADDR_W | Per-master access address, master m at slice m |
| err_bank | input | N_MASTERS*clog2(N_BANKS) | Per-master bank number |
| cfg_wr | input | 1 | Config write strobe |
| cfg_sel | input | 1 | 0 = index side, 1 = data side |
| cfg_wdata | input | 32 | Index value or clear mask |
| cfg_rdata | output | 32 | Index or selected register |
| lock_held | output | 1 | Address register is locked |

## Verification
The bench uses the default parameters: eight masters, four banks and 32-bit addresses. Eight masters fill every field of both syndrome registers, and four banks fill every bank flag position. This makes it practical to strobe every master alone in both classes and every ordered pair of masters together, so all field positions, all winner choices and every bank slot are covered. Lock take, lock refusal, partial clears and same-cycle clear-versus-record ordering are run against an arithmetic model of the registers.

// File: rtl/ecc_cap_pkg.sv
package ecc_cap_pkg;
  localparam int unsigned REG_W       = 32;
  localparam int unsigned SLOT_W      = 4;
  localparam int unsigned SLOTS_PER   = 4;
  localparam int unsigned IDX_ADDR    = 0;
  localparam int unsigned IDX_SYN0    = 1;
  localparam int unsigned IDX_SYN1    = 2;
  localparam int unsigned IDX_BANK    = 3;
  localparam logic [2:0]  ETYPE_NONE  = 3'b000;
  localparam logic [2:0]  ETYPE_UNC   = 3'b010;

  // LSB-0 positions of the MSB-0 field layout
  function automatic int unsigned type_top(input int unsigned slot);
    return REG_W - 1 - SLOT_W * slot;
  endfunction
  function automatic int unsigned rw_pos(input int unsigned slot);
    return REG_W - SLOT_W - SLOT_W * slot;
  endfunction
  function automatic int unsigned lock_pos(input int unsigned slot);
    return 15 - slot;
  endfunction
  function automatic int unsigned bank_pos(input int unsigned b);
    return 15 - b;
  endfunction
endpackage

// File: rtl/ecc_cap_arb.sv
module ecc_cap_arb #(
  parameter int unsigned N_SRC = 8,
  localparam int unsigned IW   = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
  input  logic [N_SRC-1:0] req,
  output logic             any,
  output logic [IW-1:0]    win
);
  // lowest index has priority
  always_comb begin
    any = |req;
    win = '0;
    for (int i = N_SRC - 1; i >= 0; i--) begin
      if (req[i]) win = IW'(i);
    end
  end
endmodule

// File: rtl/ecc_cap_slot.sv
module ecc_cap_slot
  import ecc_cap_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rec_hit,
  input  logic       rec_rd,
  input  logic       lock_set,
  input  logic [2:0] clr_type,
  input  logic       clr_rw,
  input  logic       clr_lock,
  output logic [2:0] type_q,
  output logic       rw_q,
  output logic       lock_q
);
  logic       empty, rec, en;
  logic [2:0] type_d;
  logic       rw_d, lock_d;

  always_comb begin
    empty  = (type_q == ETYPE_NONE);
    rec    = rec_hit & empty;
    en     = rec | lock_set | (|clr_type) | clr_rw | clr_lock;
    type_d = rec ? ETYPE_UNC : (type_q & ~clr_type);
    rw_d   = rec ? rec_rd : (rw_q & ~clr_rw);
    lock_d = lock_set | (lock_q & ~clr_lock);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      type_q <= ETYPE_NONE;
      rw_q   <= 1'b0;
      lock_q <= 1'b0;
    end else if (en) begin
      type_q <= type_d;
      rw_q   <= rw_d;
      lock_q <= lock_d;
    end
  end
endmodule

// File: rtl/ecc_cap_cfg.sv
module ecc_cap_cfg
  import ecc_cap_pkg::*;
#(
  parameter int unsigned IDX_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_wr,
  input  logic             cfg_sel,
  input  logic [REG_W-1:0] cfg_wdata,
  input  logic [REG_W-1:0] addr_word,
  input  logic [REG_W-1:0] syn0_word,
  input  logic [REG_W-1:0] syn1_word,
  input  logic [REG_W-1:0] bank_word,
  output logic [IDX_W-1:0] idx_q,
  output logic [1:0]       syn_clr_en,
  output logic             bank_clr_en,
  output logic [REG_W-1:0] cfg_rdata
);
  logic             idx_en, data_wr;
  logic [IDX_W-1:0] idx_d;

  always_comb begin
    idx_en        = cfg_wr & ~cfg_sel;
    idx_d         = cfg_wdata[IDX_W-1:0];
    data_wr       = cfg_wr & cfg_sel;
    syn_clr_en[0] = data_wr && (idx_q == IDX_W'(IDX_SYN0));
    syn_clr_en[1] = data_wr && (idx_q == IDX_W'(IDX_SYN1));
    bank_clr_en   = data_wr && (idx_q == IDX_W'(IDX_BANK));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      idx_q <= '0;
    else if (idx_en) idx_q <= idx_d;
  end

  always_comb begin
    cfg_rdata = '0;
    if (!cfg_sel) begin
      cfg_rdata = REG_W'(idx_q);
    end else begin
      if (idx_q == IDX_W'(IDX_ADDR)) cfg_rdata = addr_word;
      if (idx_q == IDX_W'(IDX_SYN0)) cfg_rdata = syn0_word;
      if (idx_q == IDX_W'(IDX_SYN1)) cfg_rdata = syn1_word;
      if (idx_q == IDX_W'(IDX_BANK)) cfg_rdata = bank_word;
    end
  end
endmodule

// File: rtl/ecc_err_capture.sv
module ecc_err_capture
  import ecc_cap_pkg::*;
#(
  parameter int unsigned N_MASTERS = 8,
  parameter int unsigned ADDR_W    = 32,
  parameter int unsigned N_BANKS   = 4,
  parameter int unsigned IDX_W     = 12
) (
  input  logic                                    clk,
  input  logic                                    rst_n,
  input  logic [N_MASTERS-1:0]                    err_valid,
  input  logic [N_MASTERS-1:0]                    err_uncorr,
  input  logic [N_MASTERS-1:0]                    err_is_read,
  input  logic [N_MASTERS-1:0]                    err_lock_req,
  input  logic [N_MASTERS*ADDR_W-1:0]             err_addr,
  input  logic [N_MASTERS*$clog2(N_BANKS)-1:0]    err_bank,
  input  logic                                    cfg_wr,
  input  logic                                    cfg_sel,
  input  logic [31:0]                             cfg_wdata,
  output logic [31:0]                             cfg_rdata,
  output logic                                    lock_held
);
  localparam int unsigned BANK_W = $clog2(N_BANKS);
  localparam int unsigned MIDX_W = (N_MASTERS > 1) ? $clog2(N_MASTERS) : 1;
  localparam int unsigned N_SYN  = 2;

  logic                 any_err, cap_en;
  logic [MIDX_W-1:0]    win;
  logic [ADDR_W-1:0]    bear_q, bear_d;
  logic [N_MASTERS-1:0] lock_set, lock_vec;
  logic [2:0]           slot_type [N_MASTERS];
  logic [N_MASTERS-1:0] slot_rw;
  logic [N_BANKS-1:0]   bank_q, bank_d, bank_set, bank_clr;
  logic                 bank_en;
  logic [1:0]           syn_clr_en;
  logic                 bank_clr_en;
  logic [IDX_W-1:0]     cfg_idx_q;
  logic [REG_W-1:0]     addr_word, bank_word;
  logic [REG_W-1:0]     syn_word [N_SYN];

  ecc_cap_arb #(.N_SRC(N_MASTERS)) u_arb (
    .req (err_valid),
    .any (any_err),
    .win (win)
  );

  // address capture
  always_comb begin
    cap_en = any_err & ~lock_held;
    bear_d = err_addr[win*ADDR_W +: ADDR_W];
    for (int m = 0; m < N_MASTERS; m++) begin
      lock_set[m] = cap_en && (win == MIDX_W'(m)) && err_lock_req[m];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      bear_q <= '0;
    else if (cap_en) bear_q <= bear_d;
  end

  // per-master syndrome slots
  for (genvar m = 0; m < N_MASTERS; m++) begin : g_slot
    localparam int unsigned SR = m / SLOTS_PER;
    localparam int unsigned SL = m % SLOTS_PER;
    localparam int unsigned TT = type_top(SL);
    localparam int unsigned RP = rw_pos(SL);
    localparam int unsigned LP = lock_pos(SL);
    logic [2:0] clr_type;
    logic       clr_rw, clr_lock;

    always_comb begin
      clr_type = cfg_wdata[TT -: 3] & {3{syn_clr_en[SR]}};
      clr_rw   = cfg_wdata[RP] & syn_clr_en[SR];
      clr_lock = cfg_wdata[LP] & syn_clr_en[SR];
    end

    ecc_cap_slot u_slot (
      .clk      (clk),
      .rst_n    (rst_n),
      .rec_hit  (err_valid[m] & err_uncorr[m]),
      .rec_rd   (err_is_read[m]),
      .lock_set (lock_set[m]),
      .clr_type (clr_type),
      .clr_rw   (clr_rw),
      .clr_lock (clr_lock),
      .type_q   (slot_type[m]),
      .rw_q     (slot_rw[m]),
      .lock_q   (lock_vec[m])
    );
  end

  assign lock_held = |lock_vec;

  // bank flags
  always_comb begin
    bank_set = '0;
    for (int m = 0; m < N_MASTERS; m++) begin
      if (err_valid[m]) bank_set[err_bank[m*BANK_W +: BANK_W]] = 1'b1;
    end
    for (int b = 0; b < N_BANKS; b++) begin
      bank_clr[b] = bank_clr_en & cfg_wdata[bank_pos(b)];
    end
    bank_en = (|bank_set) | (|bank_clr);
    bank_d  = (bank_q & ~bank_clr) | bank_set;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       bank_q <= '0;
    else if (bank_en) bank_q <= bank_d;
  end

  // register words
  always_comb begin
    addr_word = REG_W'(bear_q);
    for (int r = 0; r < N_SYN; r++) syn_word[r] = '0;
    for (int m = 0; m < N_MASTERS; m++) begin
      syn_word[m / SLOTS_PER][type_top(m % SLOTS_PER) -: 3] = slot_type[m];
      syn_word[m / SLOTS_PER][rw_pos(m % SLOTS_PER)]        = slot_rw[m];
      syn_word[m / SLOTS_PER][lock_pos(m % SLOTS_PER)]      = lock_vec[m];
    end
    bank_word = '0;
    for (int b = 0; b < N_BANKS; b++) bank_word[bank_pos(b)] = bank_q[b];
  end

  ecc_cap_cfg #(.IDX_W(IDX_W)) u_cfg (
    .clk         (clk),
    .rst_n       (rst_n),
    .cfg_wr      (cfg_wr),
    .cfg_sel     (cfg_sel),
    .cfg_wdata   (cfg_wdata),
    .addr_word   (addr_word),
    .syn0_word   (syn_word[0]),
    .syn1_word   (syn_word[1]),
    .bank_word   (bank_word),
    .idx_q       (cfg_idx_q),
    .syn_clr_en  (syn_clr_en),
    .bank_clr_en (bank_clr_en),
    .cfg_rdata   (cfg_rdata)
  );
endmodule

// File: rtl/ecc_err_capture_chk.sv
module ecc_err_capture_chk #(
  parameter int unsigned N_MASTERS = 8,
  parameter int unsigned ADDR_W    = 32,
  parameter int unsigned IDX_W     = 12
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [N_MASTERS-1:0] err_valid,
  input logic [N_MASTERS-1:0] err_lock_req,
  input logic [N_MASTERS-1:0] lock_vec,
  input logic [ADDR_W-1:0]    bear_q,
  input logic                 lock_held,
  input logic                 cfg_wr,
  input logic                 cfg_sel,
  input logic [IDX_W-1:0]     cfg_idx_q,
  input logic [31:0]          cfg_rdata
);
  p_addr_frozen_r4: assert property (@(posedge clk) disable iff (!rst_n)
    lock_held |=> $stable(bear_q));

  p_addr_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !(|err_valid) |=> $stable(bear_q));

  p_single_lock_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(lock_vec));

  p_lock_cause_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lock_held) |-> $past(|(err_valid & err_lock_req)));

  p_unlock_cause_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(lock_held) |-> $past(cfg_wr && cfg_sel));

  p_bank_reserved_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_sel && cfg_idx_q == IDX_W'(3)) |-> (cfg_rdata[11:0] == 12'h0 && cfg_rdata[31:16] == 16'h0));
endmodule

bind ecc_err_capture ecc_err_capture_chk #(
  .N_MASTERS(N_MASTERS), .ADDR_W(ADDR_W), .IDX_W(IDX_W)
) chk_i (
  .clk          (clk),
  .rst_n        (rst_n),
  .err_valid    (err_valid),
  .err_lock_req (err_lock_req),
  .lock_vec     (lock_vec),
  .bear_q       (bear_q),
  .lock_held    (lock_held),
  .cfg_wr       (cfg_wr),
  .cfg_sel      (cfg_sel),
  .cfg_idx_q    (cfg_idx_q),
  .cfg_rdata    (cfg_rdata)
);

// File: tb/ecc_err_capture_tb_top.sv
module ecc_err_capture_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NM = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NM-1:0] err_valid = '0, err_uncorr = '0, err_is_read = '0, err_lock_req = '0;
  logic [NM*32-1:0] err_addr = '0;
  logic [NM*2-1:0]  err_bank = '0;
  logic          cfg_wr = 1'b0, cfg_sel = 1'b0;
  logic [31:0]   cfg_wdata = '0;
  logic [31:0]   cfg_rdata;
  logic          lock_held;

  int checks = 0;
  int errors = 0;

  logic [31:0] m_bear;
  logic [2:0]  m_type [NM];
  logic [NM-1:0] m_rw, m_lock;
  logic [3:0]  m_bank;
  logic [11:0] m_idx;

  always #(CLK_PERIOD/2) clk = ~clk;

  ecc_err_capture dut_i (
    .clk(clk), .rst_n(rst_n), .err_valid(err_valid), .err_uncorr(err_uncorr),
    .err_is_read(err_is_read), .err_lock_req(err_lock_req), .err_addr(err_addr),
    .err_bank(err_bank), .cfg_wr(cfg_wr), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .lock_held(lock_held)
  );

  function automatic logic [31:0] addr_of(input int m, input int seed);
    return 32'h8000_0000 ^ (32'(seed) << 12) ^ (32'(m) << 4) ^ 32'h5;
  endfunction

  function automatic logic [31:0] model_word(input int k);
    logic [31:0] w = '0;
    if (k == 0) w = m_bear;
    else if (k == 1 || k == 2) begin
      for (int j = 0; j < 4; j++) begin
        w[31-4*j -: 3] = m_type[4*(k-1)+j];
        w[28-4*j]      = m_rw[4*(k-1)+j];
        w[15-j]        = m_lock[4*(k-1)+j];
      end
    end else if (k == 3) begin
      for (int b = 0; b < 4; b++) w[15-b] = m_bank[b];
    end
    return w;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic step(input logic [NM-1:0] vm, um, rm, lm, input int seed, input int bsh,
                      input bit cw, input bit cs, input logic [31:0] cd);
    bit oldlock;
    bit [NM-1:0] empty;
    int win;
    @(negedge clk);
    err_valid = vm; err_uncorr = um; err_is_read = rm; err_lock_req = lm;
    for (int m = 0; m < NM; m++) begin
      err_addr[m*32 +: 32] = addr_of(m, seed);
      err_bank[m*2 +: 2]   = 2'((m + bsh) % 4);
    end
    cfg_wr = cw; cfg_sel = cs; cfg_wdata = cd;
    @(posedge clk);
    oldlock = |m_lock;
    for (int m = 0; m < NM; m++) empty[m] = (m_type[m] == 3'b000);
    win = -1;
    for (int m = NM - 1; m >= 0; m--) if (vm[m]) win = m;
    if (cw && !cs) m_idx = cd[11:0];
    if (cw && cs) begin
      if (m_idx == 1 || m_idx == 2) begin
        for (int j = 0; j < 4; j++) begin
          m_type[4*(m_idx-1)+j] = m_type[4*(m_idx-1)+j] & ~cd[31-4*j -: 3];
          m_rw[4*(m_idx-1)+j]   = m_rw[4*(m_idx-1)+j] & ~cd[28-4*j];
          m_lock[4*(m_idx-1)+j] = m_lock[4*(m_idx-1)+j] & ~cd[15-j];
        end
      end else if (m_idx == 3) begin
        for (int b = 0; b < 4; b++) m_bank[b] = m_bank[b] & ~cd[15-b];
      end
    end
    if (win >= 0 && !oldlock) begin
      m_bear = addr_of(win, seed);
      if (lm[win]) m_lock[win] = 1'b1;
    end
    for (int m = 0; m < NM; m++) begin
      if (vm[m]) begin
        m_bank[(m + bsh) % 4] = 1'b1;
        if (um[m] && empty[m]) begin
          m_type[m] = 3'b010;
          m_rw[m]   = rm[m];
        end
      end
    end
    #1;
    err_valid = '0; err_uncorr = '0; err_is_read = '0; err_lock_req = '0;
    cfg_wr = 1'b0; cfg_sel = 1'b0; cfg_wdata = '0;
  endtask

  task automatic fire(input logic [NM-1:0] vm, um, rm, lm, input int seed, input int bsh);
    step(vm, um, rm, lm, seed, bsh, 1'b0, 1'b0, 32'h0);
  endtask

  task automatic wr_reg(input int k, input logic [31:0] v);
    step('0, '0, '0, '0, 0, 0, 1'b1, 1'b0, 32'(k));
    step('0, '0, '0, '0, 0, 0, 1'b1, 1'b1, v);
  endtask

  task automatic rd_reg(input int k, output logic [31:0] v);
    step('0, '0, '0, '0, 0, 0, 1'b1, 1'b0, 32'(k));
    cfg_sel = 1'b1;
    #1 v = cfg_rdata;
    cfg_sel = 1'b0;
  endtask

  task automatic check_all(input string req);
    logic [31:0] v;
    for (int k = 0; k < 4; k++) begin
      rd_reg(k, v);
      chk(req, v, model_word(k));
    end
    chk(req, 32'(lock_held), 32'(|m_lock));
  endtask

  task automatic clear_all();
    wr_reg(1, 32'hFFFF_FFFF);
    wr_reg(2, 32'hFFFF_FFFF);
    wr_reg(3, 32'hFFFF_FFFF);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] v;
    m_bear = '0; m_rw = '0; m_lock = '0; m_bank = '0; m_idx = '0;
    for (int m = 0; m < NM; m++) m_type[m] = 3'b000;
    repeat (3) @(posedge clk);
    #1;
    chk("R1 lock_held", 32'(lock_held), 32'h0);
    chk("R1 index", cfg_rdata, 32'h0);
    @(negedge clk); rst_n = 1'b1;
    check_all("R1");

    // R11: index readback through cfg_sel=0
    step('0, '0, '0, '0, 0, 0, 1'b1, 1'b0, 32'hABCD_E9A5);
    #1 chk("R11 index readback", cfg_rdata, 32'h0000_09A5);
    cfg_sel = 1'b1;
    #1 chk("R10 out-of-range index", cfg_rdata, 32'h0);
    cfg_sel = 1'b0;

    // R10: writes to address register and reserved bits are ignored
    fire(8'h01, 8'h00, 8'h00, 8'h00, 7, 0);
    wr_reg(0, 32'hFFFF_FFFF);
    check_all("R10 address write ignored");
    wr_reg(3, 32'h0000_0FFF);
    check_all("R10 reserved bank bits");
    clear_all();

    // R2 R6 R9: each master alone, uncorrectable, both directions
    for (int m = 0; m < NM; m++) begin
      fire(8'(1 << m), 8'(1 << m), 8'((m % 2) << m), 8'h00, m + 1, m % 3);
      check_all("R2 R6 R9 single uncorrectable");
      clear_all();
      check_all("R8 full clear");
    end

    // R6: correctable errors leave the type field, still capture the address
    for (int m = 0; m < NM; m++) begin
      fire(8'(1 << m), 8'h00, 8'hFF, 8'h00, 20 + m, 1);
      check_all("R6 correctable");
    end
    clear_all();

    // R12 R2: every ordered pair of masters together
    for (int a = 0; a < NM; a++) begin
      for (int b = 0; b < NM; b++) begin
        fire(8'((1 << a) | (1 << b)), 8'hFF, 8'(1 << b), 8'h00, 40 + a * 8 + b, a);
        check_all("R12 R2 pair");
        clear_all();
      end
    end

    // R3 R4 R5: lock take, hold, refusal and release
    fire(8'h20, 8'h20, 8'h20, 8'h20, 100, 0);
    check_all("R3 lock taken by master 5");
    chk("R3 lock_held", 32'(lock_held), 32'h1);
    fire(8'h01, 8'h01, 8'h00, 8'h00, 101, 0);
    check_all("R4 locked ignores master 0");
    fire(8'h02, 8'h00, 8'h00, 8'h02, 102, 0);
    check_all("R3 second lock refused");
    wr_reg(1, 32'h0000_F000);
    check_all("R5 clearing other register keeps lock");
    wr_reg(2, 32'h0000_B000);
    check_all("R5 clear of empty lock bits keeps lock");
    chk("R5 still locked", 32'(lock_held), 32'h1);
    wr_reg(2, 32'h0000_4000);
    check_all("R5 lock released");
    chk("R5 unlocked", 32'(lock_held), 32'h0);
    fire(8'h08, 8'h00, 8'h00, 8'h00, 103, 0);
    check_all("R5 capture after release");
    clear_all();

    // R7: first error kept
    fire(8'h04, 8'h04, 8'h00, 8'h00, 110, 0);
    fire(8'h04, 8'h04, 8'h04, 8'h00, 111, 0);
    check_all("R7 first record kept");
    // R8: partial clear of the direction bit only
    fire(8'h40, 8'h40, 8'h40, 8'h00, 112, 0);
    wr_reg(2, 32'h0010_0000);
    check_all("R8 partial clear");
    // R8: same-cycle clear with records: master 2 full (cleared), master 3 empty (recorded)
    step('0, '0, '0, '0, 0, 0, 1'b1, 1'b0, 32'h1);
    step(8'h0C, 8'h0C, 8'h08, 8'h00, 113, 2, 1'b1, 1'b1, 32'hFFFF_FFFF);
    check_all("R8 record wins over clear");
    rd_reg(1, v);
    chk("R8 master 3 field", {28'h0, v[19:16]}, 32'h5);
    chk("R8 master 2 field", {28'h0, v[23:20]}, 32'h0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule